// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Controller

This block decides, cycle by cycle, whether the CPU core takes an interrupt and which one. Each of a parameterised set of maskable request lines carries a programmable 4-bit priority level. A request competes only when its level is strictly above the current mask level. Acceptance is held off by the block bit, and may also be held off by a mode in which a low level on the non-maskable pin gates every maskable source. The non-maskable input is synchronised, edge-detected on a selectable edge, and always takes precedence.

On acceptance the block emits a one-cycle pulse and an event code that software uses as a dispatch offset. In the same update it sets the block bit. When the automatic-update mode is on, it also loads the mask level with the accepted level. The block bit and mask level live here and are written by software through simple write strobes. Clearing the block bit inside a handler lets a higher-level request in at once, which gives nested interrupts.

Top module: `intc_accept`

## Requirements
- R1: While the block bit (`sr_bl`) is 1, no maskable request is accepted. A qualifying request that is already pending is accepted on the first clock edge after software clears the bit.
- R2: A maskable request is eligible only when its priority level is strictly greater than `sr_imask`. A level of 0 never qualifies.
- R3: Among eligible requests, the highest level wins. Equal levels resolve to the lowest source index.
- R4: With `mode_intmu` = 1, acceptance loads `sr_imask` with the accepted level, or with 15 for the non-maskable source.
- R5: With `mode_intmu` = 0, acceptance leaves `sr_imask` unchanged.
- R6: With `mode_mai` = 1 and the synchronised `nmi_pin` low, no maskable request is accepted, whatever `sr_bl` and `sr_imask` hold.
- R7: The non-maskable source triggers only on the selected edge of `nmi_pin` (`nmi_rise_sel` = 0 for falling, 1 for rising). It passes a two-flop synchroniser, and `acc_pulse` rises on the fourth rising clock edge after the pin changes. The pending flag holds until the source is accepted.
- R8: A pending non-maskable event is accepted ahead of any maskable request, regardless of `sr_bl` and `sr_imask`.
- R9: `acc_code` is EVT_BASE + EVT_STEP × index for a maskable source (defaults 0x200 and 0x20), and NMI_CODE (default 0x1C0) for the non-maskable source. `acc_is_nmi` is 1 only for the latter.
- R10: `acc_pulse` is high for one cycle per acceptance, and `sr_bl` reads 1 in that same cycle.
- R11: After reset, `acc_pulse` = 0, `acc_code` = 0, `acc_is_nmi` = 0, `sr_bl` = 1, `sr_imask` = 15, and every priority level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | N_SRC | Maskable request lines, level sensitive |
| prio_we | input | 1 | Priority level write strobe |
| prio_idx | input | IDX_W | Source selected for the priority write |
| prio_lvl | input | 4 | Priority level to write |
| sr_bl_we | input | 1 | Block bit write strobe |
| sr_bl_wdata | input | 1 | Block bit write value |
| sr_imask_we | input | 1 | Mask level write strobe |
| sr_imask_wdata | input | 4 | Mask level write value |
| mode_intmu | input | 1 | Automatic mask level update on acceptance |
| mode_mai | input | 1 | Gate all maskable sources while nmi_pin is low |
| nmi_pin | input | 1 | Asynchronous non-maskable pin |
| nmi_rise_sel | input | 1 | 0 selects the falling edge, 1 the rising edge |
| acc_pulse | output | 1 | One-cycle acceptance pulse |
| acc_code | output | CODE_W | Event code of the accepted source |
| acc_is_nmi | output | 1 | Accepted source was the non-maskable one |
| sr_bl | output | 1 | Current block bit |
| sr_imask | output | 4 | Current mask level |

## Verification
Register writes and maskable requests driven before an edge take effect at that edge. The bench therefore samples `acc_pulse`, `acc_code`, `sr_bl` and `sr_imask` one nanosecond after the edge that follows the stimulus. A pin change reaches `acc_pulse` only after the fourth edge, so the bench checks that the pulse is still low after the third edge and high after the fourth. The checks on `mode_mai` release count the two synchroniser edges before the third edge accepts. In the precedence test, the block-bit write is placed so that it lands on the same edge as the pending flag, which makes both sources eligible at once.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LVL_W = 4;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_TOP = '1;
endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/intc_prio_bank.sv
module intc_prio_bank
  import intc_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  lvl_t                        wr_lvl,
  output logic [N_SRC-1:0][LVL_W-1:0] lvl_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic hit;
    lvl_t lvl_d;
    lvl_t lvl_q;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      lvl_d = lvl_q;
      if (hit) lvl_d = wr_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lvl_q <= '0;
      else if (hit) lvl_q <= lvl_d;
    end

    assign lvl_o[g] = lvl_q;
  end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick
  import intc_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]            req,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl,
  input  lvl_t                        thr,
  output logic                        hit,
  output logic [IDX_W-1:0]            idx,
  output lvl_t                        win_lvl
);
  // Scan from the top index down with >= so that a lower index overrides an
  // equal level found earlier in the scan.
  always_comb begin
    hit     = 1'b0;
    idx     = '0;
    win_lvl = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i] && (lvl[i] > thr) && (lvl[i] >= win_lvl)) begin
        hit     = 1'b1;
        idx     = IDX_W'(i);
        win_lvl = lvl[i];
      end
    end
  end
endmodule

// File: rtl/intc_nmi_detect.sv
module intc_nmi_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  input  logic take,
  output logic level,
  output logic pend
);
  logic s1_q, s2_q, s3_q;
  logic pend_q, pend_d;
  logic edge_hit;

  always_comb begin
    edge_hit = rise_sel ? (s2_q && !s3_q) : (!s2_q && s3_q);
    pend_d   = pend_q;
    if (take)     pend_d = 1'b0;
    if (edge_hit) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      s3_q   <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      pend_q <= pend_d;
    end
  end

  assign level = s2_q;
  assign pend  = pend_q;

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !take |=> pend_q); // R7
endmodule

// File: rtl/intc_mask_ctrl.sv
module intc_mask_ctrl
  import intc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bl_we,
  input  logic bl_wdata,
  input  logic imask_we,
  input  lvl_t imask_wdata,
  input  logic acc_any,
  input  logic acc_nmi,
  input  lvl_t acc_lvl,
  input  logic intmu,
  output logic bl,
  output lvl_t imask
);
  logic bl_q, bl_d, bl_en;
  lvl_t imask_q, imask_d;
  logic imask_en, auto_ld;

  always_comb begin
    auto_ld  = acc_any && intmu;
    bl_en    = acc_any || bl_we;
    bl_d     = acc_any ? 1'b1 : bl_wdata;
    imask_en = auto_ld || imask_we;
    if (auto_ld) imask_d = acc_nmi ? LVL_TOP : acc_lvl;
    else         imask_d = imask_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_q    <= 1'b1;
      imask_q <= LVL_TOP;
    end else begin
      if (bl_en)    bl_q    <= bl_d;
      if (imask_en) imask_q <= imask_d;
    end
  end

  assign bl    = bl_q;
  assign imask = imask_q;

  AST_INTMU_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_any && !acc_nmi && intmu |=> imask_q == $past(acc_lvl)); // R4
  AST_IMASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_any && !intmu && !imask_we |=> $stable(imask_q)); // R5
endmodule

// File: rtl/intc_accept.sv
module intc_accept
  import intc_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int CODE_W = 12,
  parameter logic [CODE_W-1:0] EVT_BASE = 12'h200,
  parameter logic [CODE_W-1:0] EVT_STEP = 12'h020,
  parameter logic [CODE_W-1:0] NMI_CODE = 12'h1C0,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic              prio_we,
  input  logic [IDX_W-1:0]  prio_idx,
  input  logic [3:0]        prio_lvl,
  input  logic              sr_bl_we,
  input  logic              sr_bl_wdata,
  input  logic              sr_imask_we,
  input  logic [3:0]        sr_imask_wdata,
  input  logic              mode_intmu,
  input  logic              mode_mai,
  input  logic              nmi_pin,
  input  logic              nmi_rise_sel,
  output logic              acc_pulse,
  output logic [CODE_W-1:0] acc_code,
  output logic              acc_is_nmi,
  output logic              sr_bl,
  output logic [3:0]        sr_imask
);
  logic                        rst_n_s;
  logic [N_SRC-1:0][LVL_W-1:0] lvl_tab;
  logic                        win_hit;
  logic [IDX_W-1:0]            win_idx;
  lvl_t                        win_lvl;
  logic                        nmi_lvl, nmi_pend;
  logic                        gate_mai, acc_nmi, acc_mask, acc_any;
  logic [CODE_W-1:0]           code_d;
  logic                        ack_q, nmi_q;
  logic [CODE_W-1:0]           code_q;
  logic                        bl_cur;
  lvl_t                        imask_cur;

  intc_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  intc_prio_bank #(.N_SRC(N_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n_s), .wr_en(prio_we), .wr_idx(prio_idx),
    .wr_lvl(prio_lvl), .lvl_o(lvl_tab)
  );

  intc_prio_pick #(.N_SRC(N_SRC)) u_pick (
    .req(irq_req), .lvl(lvl_tab), .thr(imask_cur),
    .hit(win_hit), .idx(win_idx), .win_lvl(win_lvl)
  );

  intc_nmi_detect u_nmi (
    .clk(clk), .rst_n(rst_n_s), .pin(nmi_pin), .rise_sel(nmi_rise_sel),
    .take(acc_nmi), .level(nmi_lvl), .pend(nmi_pend)
  );

  intc_mask_ctrl u_mask (
    .clk(clk), .rst_n(rst_n_s),
    .bl_we(sr_bl_we), .bl_wdata(sr_bl_wdata),
    .imask_we(sr_imask_we), .imask_wdata(sr_imask_wdata),
    .acc_any(acc_any), .acc_nmi(acc_nmi), .acc_lvl(win_lvl),
    .intmu(mode_intmu), .bl(bl_cur), .imask(imask_cur)
  );

  // Acceptance decision
  always_comb begin
    gate_mai = mode_mai && !nmi_lvl;
    acc_nmi  = nmi_pend;
    acc_mask = !nmi_pend && !bl_cur && !gate_mai && win_hit;
    acc_any  = acc_nmi || acc_mask;
    if (acc_nmi) code_d = NMI_CODE;
    else         code_d = EVT_BASE + EVT_STEP * CODE_W'(win_idx);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ack_q  <= 1'b0;
      nmi_q  <= 1'b0;
      code_q <= '0;
    end else begin
      ack_q <= acc_any;
      if (acc_any) begin
        nmi_q  <= acc_nmi;
        code_q <= code_d;
      end
    end
  end

  assign acc_pulse  = ack_q;
  assign acc_code   = code_q;
  assign acc_is_nmi = nmi_q;
  assign sr_bl      = bl_cur;
  assign sr_imask   = imask_cur;

  AST_BL_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n_s)
    ack_q && !nmi_q |-> !$past(bl_cur)); // R1
  AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n_s)
    ack_q && !nmi_q |-> $past(win_lvl) > $past(imask_cur)); // R2
  AST_WINNER_REQ: assert property (@(posedge clk) disable iff (!rst_n_s)
    win_hit |-> irq_req[win_idx]); // R3
  AST_MAI_GATE: assert property (@(posedge clk) disable iff (!rst_n_s)
    ack_q && !nmi_q |-> !$past(mode_mai && !nmi_lvl)); // R6
  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n_s)
    ack_q && !nmi_q |-> !$past(nmi_pend)); // R8
  AST_BL_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n_s)
    ack_q |-> bl_cur); // R10
endmodule

// File: tb/tb_intc_accept.sv
module tb_intc_accept;
  localparam int N = 8;

  logic        clk;
  logic        rst_n;
  logic [N-1:0] irq_req;
  logic        prio_we;
  logic [2:0]  prio_idx;
  logic [3:0]  prio_lvl;
  logic        sr_bl_we, sr_bl_wdata, sr_imask_we;
  logic [3:0]  sr_imask_wdata;
  logic        mode_intmu, mode_mai, nmi_pin, nmi_rise_sel;
  logic        acc_pulse, acc_is_nmi, sr_bl;
  logic [11:0] acc_code;
  logic [3:0]  sr_imask;

  int n_run = 0;
  int n_fail = 0;

  intc_accept dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .prio_we(prio_we), .prio_idx(prio_idx), .prio_lvl(prio_lvl),
    .sr_bl_we(sr_bl_we), .sr_bl_wdata(sr_bl_wdata),
    .sr_imask_we(sr_imask_we), .sr_imask_wdata(sr_imask_wdata),
    .mode_intmu(mode_intmu), .mode_mai(mode_mai),
    .nmi_pin(nmi_pin), .nmi_rise_sel(nmi_rise_sel),
    .acc_pulse(acc_pulse), .acc_code(acc_code), .acc_is_nmi(acc_is_nmi),
    .sr_bl(sr_bl), .sr_imask(sr_imask)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Per-source levels used throughout
  localparam logic [3:0] LV [N] = '{4'd3, 4'd5, 4'd5, 4'd0, 4'd9, 4'd1, 4'd12, 4'd9};

  // {req[20:13], imask[12:9], intmu[8], exp_ack[7], exp_src[6:4], exp_imask[3:0]}
  localparam logic [20:0] VEC [10] = '{
    {8'h01, 4'd0,  1'b1, 1'b1, 3'd0, 4'd3 },
    {8'h06, 4'd0,  1'b0, 1'b1, 3'd1, 4'd0 },
    {8'h06, 4'd5,  1'b0, 1'b0, 3'd0, 4'd5 },
    {8'h08, 4'd0,  1'b1, 1'b0, 3'd0, 4'd0 },
    {8'hFF, 4'd0,  1'b1, 1'b1, 3'd6, 4'd12},
    {8'hB0, 4'd9,  1'b1, 1'b0, 3'd0, 4'd9 },
    {8'h90, 4'd3,  1'b0, 1'b1, 3'd4, 4'd3 },
    {8'h40, 4'd11, 1'b1, 1'b1, 3'd6, 4'd12},
    {8'h20, 4'd0,  1'b1, 1'b1, 3'd5, 4'd1 },
    {8'h40, 4'd15, 1'b1, 1'b0, 3'd0, 4'd15}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] code_of(input int src);
    return 12'h200 + 12'h020 * 12'(src);
  endfunction

  task automatic write_sr(input logic bl, input logic [3:0] im);
    sr_bl_we = 1'b1; sr_bl_wdata = bl;
    sr_imask_we = 1'b1; sr_imask_wdata = im;
    tick();
    sr_bl_we = 1'b0; sr_imask_we = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    irq_req = '0; prio_we = 0; prio_idx = 0; prio_lvl = 0;
    sr_bl_we = 0; sr_bl_wdata = 0; sr_imask_we = 0; sr_imask_wdata = 0;
    mode_intmu = 0; mode_mai = 0; nmi_pin = 1; nmi_rise_sel = 0;
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();

    // R11 reset state
    check("R11", "acc_pulse", 32'(acc_pulse), 0);
    check("R11", "acc_code", 32'(acc_code), 0);
    check("R11", "acc_is_nmi", 32'(acc_is_nmi), 0);
    check("R11", "sr_bl", 32'(sr_bl), 1);
    check("R11", "sr_imask", 32'(sr_imask), 15);
    // R11 levels all zero: nothing accepted even with mask 0 and BL clear
    irq_req = 8'hFF;
    write_sr(1'b0, 4'd0);
    tick();
    check("R11", "no level programmed", 32'(acc_pulse), 0);
    irq_req = '0;

    for (int i = 0; i < N; i++) begin
      prio_we = 1; prio_idx = 3'(i); prio_lvl = LV[i];
      tick();
    end
    prio_we = 0;

    // Vector table: R2 R3 R4 R5 R9
    for (int k = 0; k < 10; k++) begin
      logic [20:0] v;
      v = VEC[k];
      irq_req = '0;
      mode_intmu = v[8];
      write_sr(1'b0, v[12:9]);
      irq_req = v[20:13];
      tick();
      check("R2/R3", $sformatf("vec%0d ack", k), 32'(acc_pulse), 32'(v[7]));
      if (v[7]) begin
        check("R3/R9", $sformatf("vec%0d code", k), 32'(acc_code), 32'(code_of(int'(v[6:4]))));
        check("R10", $sformatf("vec%0d bl", k), 32'(sr_bl), 1);
      end
      check(v[8] ? "R4" : "R5", $sformatf("vec%0d imask", k), 32'(sr_imask), 32'(v[3:0]));
      irq_req = '0;
      tick();
    end

    // R1: BL set blocks; clearing it admits the pending request at once
    mode_intmu = 1;
    write_sr(1'b1, 4'd0);
    irq_req = 8'h40;
    tick(); tick();
    check("R1", "ack while bl=1", 32'(acc_pulse), 0);
    sr_bl_we = 1; sr_bl_wdata = 0;
    tick();
    sr_bl_we = 0;
    check("R1", "ack on bl-clear edge", 32'(acc_pulse), 0);
    tick();
    check("R1", "ack after bl clear", 32'(acc_pulse), 1);
    check("R9", "code src6", 32'(acc_code), 32'(code_of(6)));
    check("R10", "bl set on ack", 32'(sr_bl), 1);
    tick();
    check("R10", "pulse one cycle", 32'(acc_pulse), 0);
    // nested: higher level source admitted above raised mask
    prio_we = 1; prio_idx = 3'd1; prio_lvl = 4'd14;
    tick();
    prio_we = 0;
    irq_req = 8'h42;
    sr_bl_we = 1; sr_bl_wdata = 0;
    tick();
    sr_bl_we = 0;
    tick();
    check("R1", "nested ack", 32'(acc_pulse), 1);
    check("R3", "nested code", 32'(acc_code), 32'(code_of(1)));
    check("R4", "nested imask", 32'(sr_imask), 14);
    irq_req = '0;
    tick();

    // R7/R8/R6: falling edge NMI under MAI while BL=1
    mode_mai = 1;
    sr_imask_we = 1; sr_imask_wdata = 0;
    tick();
    sr_imask_we = 0;
    nmi_pin = 0;
    tick(); tick(); tick();
    check("R7", "no ack after 3 edges", 32'(acc_pulse), 0);
    tick();
    check("R7", "nmi ack on 4th edge", 32'(acc_pulse), 1);
    check("R8", "nmi flag", 32'(acc_is_nmi), 1);
    check("R9", "nmi code", 32'(acc_code), 32'h1C0);
    check("R4", "nmi imask 15", 32'(sr_imask), 15);
    tick();
    check("R7", "nmi pulse single", 32'(acc_pulse), 0);
    irq_req = 8'h40;
    write_sr(1'b0, 4'd0);
    tick(); tick();
    check("R6", "gated ack", 32'(acc_pulse), 0);
    check("R6", "bl untouched", 32'(sr_bl), 0);
    nmi_pin = 1;
    tick(); tick();
    check("R6", "still gated in sync", 32'(acc_pulse), 0);
    tick();
    check("R6", "ack after pin high", 32'(acc_pulse), 1);
    check("R7", "rising ignored when falling selected", 32'(acc_is_nmi), 0);
    irq_req = '0;
    mode_mai = 0;
    tick();

    // R7 wrong edge, then R8 precedence with both sources eligible
    nmi_rise_sel = 1;
    mode_intmu = 0;
    nmi_pin = 0;
    for (int j = 0; j < 5; j++) begin
      tick();
      check("R7", "falling ignored when rising selected", 32'(acc_pulse), 0);
    end
    nmi_pin = 1;
    tick(); tick();
    irq_req = 8'h40;
    write_sr(1'b0, 4'd0);
    check("R7", "no ack before 4th edge", 32'(acc_pulse), 0);
    tick();
    check("R8", "nmi ack", 32'(acc_pulse), 1);
    check("R8", "nmi wins", 32'(acc_is_nmi), 1);
    check("R5", "imask kept on nmi", 32'(sr_imask), 0);
    tick();
    check("R10", "no maskable after nmi", 32'(acc_pulse), 0);
    irq_req = '0;
    tick();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule